// File: doc/BRIEF.md
# Serial ADC Readout Port Model

This block is a synthesizable stand-in for the digital side of a successive-approximation converter's three-wire serial port. It is meant as a test partner for host-side readout logic. A testbench or a register supplies a parallel code as the "analog" value. The host drives an active-low select and a data clock. The block answers on a serial data line, together with an output-enable that models the tri-state driver.

Everything is sampled on a fast system clock. Falling edges of the data clock are found by comparing the data clock with its value one system cycle earlier. A saturating edge counter is cleared whenever select is high, and each frame is built from that counter.

The frame runs as follows:
- The first edge captures the code. It is combined into a word of `FRAME_W` bits, in which the `FRAME_W-RES` low bits are zero.
- The second edge enables the driver with a low null bit.
- The word then follows MSB first.
- The word follows again LSB first.
- Zeros follow until select rises.

Top module: `adc_serial_emu`

## Requirements
- R1: While `cs_n` is sampled high, `sdo_oe` is low from the next system clock edge, and `sdo` is low whenever `sdo_oe` is low.
- R2: On the 1st data-clock falling edge after `cs_n` falls, the output stays disabled and `code` is captured.
- R3: On the 2nd falling edge, `sdo_oe` rises and `sdo` drives a low null bit, only ever after a falling edge.
- R4: On falling edges 3 to `FRAME_W+2`, `sdo` gives word bits `FRAME_W-1` down to 0, MSB first.
- R5: On edges `FRAME_W+3` to `2*FRAME_W+1`, `sdo` gives word bits 1 up to `FRAME_W-1`, LSB first. Bit 0 is shared with the end of the MSB-first run and is not sent twice.
- R6: From edge `2*FRAME_W+2` on, `sdo` stays low with `sdo_oe` high for any number of further edges. The edge counter saturates and does not wrap.
- R7: Changes of `code` after the capture edge have no effect on the frame in progress.
- R8: A frame cut short by `cs_n` rising restarts cleanly at edge 1 on the next fall of `cs_n`, using the newly presented code.
- R9: Data-clock edges while `cs_n` is high are ignored: the output stays disabled, and the next frame still begins with edge 1.
- R10: The word is `{code, FRAME_W-RES zeros}`, so the bits below the resolution are sent as zero.
- R11: After reset, `sdo_oe` and `sdo` are low.
- R12: With `cs_n` low, `sdo` and `sdo_oe` change only at the system edge where a data-clock falling edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high means power-down |
| sclk | input | 1 | Data clock from the host |
| code | input | RES | Parallel value standing in for the converted input |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Driver enable; low means high impedance |

## Verification
The bench builds the block with `RES=10` and `FRAME_W=12`. This brings the two zero pad bits into both the MSB-first and the LSB-first runs, so the padding and the shared bit 0 are observed on the line. A full frame at these settings is 26 edges. Running 40 extra edges drives the 5-bit counter past the value where it would wrap, which makes saturation visible on the output.

// File: rtl/adcser_pkg.sv
package adcser_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_NULL,
    PH_MSB,
    PH_LSB,
    PH_ZERO
  } adcser_phase_e;
endpackage

// File: rtl/adcser_edge.sv
module adcser_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign fall = sclk_q & ~sclk;
endmodule

// File: rtl/adcser_counter.sv
module adcser_counter #(
  parameter int CNT_W   = 5,
  parameter int CNT_MAX = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (cs_n)
      cnt_nxt = '0;
    else if (step && (cnt_q != MAX_V))
      cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/adcser_shaper.sv
module adcser_shaper
  import adcser_pkg::*;
#(
  parameter int RES     = 10,
  parameter int FRAME_W = 12,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [RES-1:0]   code,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int PAD = FRAME_W - RES;
  localparam logic [CNT_W-1:0] C_SAMPLE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_NULL    = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_MSB_END = CNT_W'(FRAME_W + 2);
  localparam logic [CNT_W-1:0] C_LSB_END = CNT_W'(2 * FRAME_W + 1);

  logic [RES-1:0]     code_q, code_d;
  logic [FRAME_W-1:0] word, shifted;
  logic               sdo_d, oe_d;
  adcser_phase_e      phase;

  generate
    if (PAD > 0) begin : g_pad
      assign word = {code_q, {PAD{1'b0}}};
    end else begin : g_nopad
      assign word = code_q;
    end
  endgenerate

  // capture enable: first detected fall of the frame
  always_comb begin
    code_d = code_q;
    if (step && (cnt_nxt == C_SAMPLE))
      code_d = code;
  end

  always_comb begin
    if (cnt_nxt == '0)              phase = PH_IDLE;
    else if (cnt_nxt == C_SAMPLE)   phase = PH_SAMPLE;
    else if (cnt_nxt == C_NULL)     phase = PH_NULL;
    else if (cnt_nxt <= C_MSB_END)  phase = PH_MSB;
    else if (cnt_nxt <= C_LSB_END)  phase = PH_LSB;
    else                            phase = PH_ZERO;
  end

  always_comb begin
    shifted = '0;
    sdo_d   = 1'b0;
    oe_d    = 1'b0;
    unique case (phase)
      PH_IDLE, PH_SAMPLE: begin
        oe_d = 1'b0;
      end
      PH_NULL, PH_ZERO: begin
        oe_d = 1'b1;
      end
      PH_MSB: begin
        oe_d    = 1'b1;
        shifted = word >> (C_MSB_END - cnt_nxt);
        sdo_d   = shifted[0];
      end
      PH_LSB: begin
        oe_d    = 1'b1;
        shifted = word >> (cnt_nxt - C_MSB_END);
        sdo_d   = shifted[0];
      end
      default: begin
        oe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      code_q <= code_d;
      sdo    <= sdo_d;
      sdo_oe <= oe_d;
    end
  end
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu #(
  parameter int RES     = 10,
  parameter int FRAME_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic [RES-1:0] code,
  output logic           sdo,
  output logic           sdo_oe
);
  localparam int CNT_MAX = 2 * FRAME_W + 2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             rst_meta, rst_sync;
  logic             fall;
  logic [CNT_W-1:0] cnt_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  adcser_edge u_edge (
    .clk   (clk),
    .rst_n (rst_sync),
    .sclk  (sclk),
    .fall  (fall)
  );

  adcser_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync),
    .cs_n    (cs_n),
    .step    (fall),
    .cnt_nxt (cnt_nxt)
  );

  adcser_shaper #(.RES(RES), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shape (
    .clk     (clk),
    .rst_n   (rst_sync),
    .step    (fall),
    .cnt_nxt (cnt_nxt),
    .code    (code),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );
endmodule

// File: rtl/adcser_checker.sv
module adcser_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe
);
  p_hiz_on_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  p_low_when_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  p_null_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  p_enable_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !$past(sclk));

  // R12: no detected fall at the previous edge while selected -> outputs hold
  p_hold_between_edges_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n) && !($past(sclk, 2) && !$past(sclk)))
      |-> ($stable(sdo) && $stable(sdo_oe)));
endmodule

bind adc_serial_emu adcser_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .sclk   (sclk),
  .sdo    (sdo),
  .sdo_oe (sdo_oe)
);

// File: tb/adc_serial_emu_tb.sv
module adc_serial_emu_tb;
  localparam int RES = 10;
  localparam int FW  = 12;
  localparam int NV  = 7;

  localparam logic [RES-1:0] CODES [NV] = '{10'h000, 10'h3FF, 10'h200, 10'h1FF,
                                             10'h2AA, 10'h155, 10'h001};
  localparam logic [FW-1:0]  WORDS [NV] = '{12'h000, 12'hFFC, 12'h800, 12'h7FC,
                                             12'hAA8, 12'h554, 12'h004};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic [RES-1:0] code = '0;
  logic sdo, sdo_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  adc_serial_emu #(.RES(RES), .FRAME_W(FW)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .code   (code),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_sdo(input logic [FW-1:0] w, input int k);
    logic [FW-1:0] t;
    if (k <= 2) return 1'b0;
    if (k <= FW + 2) begin t = w >> (FW + 2 - k); return t[0]; end
    if (k <= 2 * FW + 1) begin t = w >> (k - FW - 2); return t[0]; end
    return 1'b0;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    @(negedge clk); sclk = 1'b0;
    wait_clk(3);
    @(negedge clk); sclk = 1'b1;
    wait_clk(3);
  endtask

  // one falling edge, then check the state it produced (edge number k)
  task automatic edge_chk(input int k, input logic [FW-1:0] w, input string tag);
    @(negedge clk); sclk = 1'b0;
    wait_clk(3);
    chk(sdo_oe == (k >= 2), {tag, " oe"}, {15'd0, sdo_oe}, {15'd0, (k >= 2)});
    chk(sdo == exp_sdo(w, k), {tag, " sdo"}, {15'd0, sdo}, {15'd0, exp_sdo(w, k)});
    @(negedge clk); sclk = 1'b1;
    wait_clk(3);
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0;
    wait_clk(3);
  endtask

  task automatic cs_high_chk(input string tag);
    @(negedge clk); cs_n = 1'b1;
    wait_clk(2);
    chk(!sdo_oe, {tag, " R1 hiz"}, {15'd0, sdo_oe}, 16'd0);
    chk(!sdo, {tag, " R1 low"}, {15'd0, sdo}, 16'd0);
  endtask

  function automatic string edge_tag(input int k);
    if (k == 1) return "R2";
    if (k == 2) return "R3";
    if (k <= FW + 2) return "R4";
    if (k <= 2 * FW + 1) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R11 reset state
    chk(!sdo_oe, "R11 oe", {15'd0, sdo_oe}, 16'd0);
    chk(!sdo, "R11 sdo", {15'd0, sdo}, 16'd0);

    // table walk: full frames, R10 padding visible in expected words
    for (int v = 0; v < NV; v++) begin
      code = CODES[v];
      cs_low();
      for (int k = 1; k <= 2 * FW + 4; k++)
        edge_chk(k, WORDS[v], $sformatf("%s R10 vec%0d edge%0d", edge_tag(k), v, k));
      cs_high_chk($sformatf("vec%0d", v));
    end

    // R9: clocks while deselected are ignored
    code = 10'h2AA;
    for (int i = 0; i < 5; i++) begin
      pulse_sclk();
      chk(!sdo_oe, "R9 deselected clocks", {15'd0, sdo_oe}, 16'd0);
    end
    cs_low();
    for (int k = 1; k <= 4; k++)
      edge_chk(k, 12'hAA8, $sformatf("R9 restart edge%0d", k));
    cs_high_chk("R9");

    // R7: code change after capture has no effect
    code = 10'h3FF;
    cs_low();
    edge_chk(1, 12'hFFC, "R7 edge1");
    code = 10'h000;
    for (int k = 2; k <= 2 * FW + 2; k++)
      edge_chk(k, 12'hFFC, $sformatf("R7 edge%0d", k));
    cs_high_chk("R7");

    // R8: cut frame, restart with new code
    code = 10'h155;
    cs_low();
    for (int k = 1; k <= 5; k++)
      edge_chk(k, 12'h554, $sformatf("R8 cut edge%0d", k));
    cs_high_chk("R8 cut");
    code = 10'h2AA;
    cs_low();
    for (int k = 1; k <= 2 * FW + 2; k++)
      edge_chk(k, 12'hAA8, $sformatf("R8 restart edge%0d", k));

    // R6: long tail of zeros past the counter wrap point
    for (int k = 2 * FW + 3; k <= 2 * FW + 43; k++)
      edge_chk(k, 12'hAA8, $sformatf("R6 tail edge%0d", k));
    cs_high_chk("R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule